// File: doc/BRIEF.md
# Activity-Based Two-Input Source Selector

This block decides which of two video inputs a downstream decoder processes. Each input supplies a raw flag that says whether sync was seen on the current line. A strobe marks each line boundary. Every flag is filtered over a run of consecutive lines before it counts as activity. The filtered activity of both inputs is reported on a two-bit status word.

In manual mode a single select bit names the input. In automatic mode a fixed rule picks the input, and that rule is deliberately asymmetric. Input A wins whenever both inputs are active and whenever neither is active. Input B is taken when it alone is active. Once input B is taken, it is held for as long as B stays active, even if A comes back in the meantime. Selection is registered, and a one-cycle pulse marks every change of source.

Top module: `input_autosel`

## Requirements
- R1: With `auto_en` low, `sel_src` takes the value of `manual_sel` on the clock edge after it is sampled.
- R2: While `rst` is high, and on the first cycle after it, `sel_src` is 0 (input A), `act_status` is 2'b00 and `sel_switch` is 0.
- R3: In automatic mode, when neither input is active, `sel_src` becomes or stays 0. This includes a return from input B.
- R4: In automatic mode, when input B is active and input A is not, `sel_src` becomes 1.
- R5: In automatic mode, when both inputs are active while input A is selected, input A stays selected. This includes both inputs being active right after reset.
- R6: In automatic mode, once input B is selected it stays selected while B is active, whatever A does. It returns to A only when B becomes inactive.
- R7: An input's activity bit rises only on the DEB_LINES-th consecutive line strobe with its sync flag high. Fewer consecutive lines leave it low.
- R8: An input's activity bit falls only after DEB_LINES consecutive strobes with its sync flag low. A strobe that agrees with the current state restarts the count.
- R9: `act_status` bit 0 is input A's activity and bit 1 is input B's activity. It changes only on the clock edge that samples `line_tick` high.
- R10: `sel_src` encodes input A as 0 and input B as 1. `sel_switch` is high for exactly the cycles in which `sel_src` differs from its previous value.
- R11: In automatic mode, a selection change caused by an activity change appears one clock edge after the `act_status` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle strobe at each line boundary |
| sync_a | input | 1 | Sync seen on input A during the line ending at this strobe |
| sync_b | input | 1 | Sync seen on input B during the line ending at this strobe |
| auto_en | input | 1 | 1 = automatic selection, 0 = manual |
| manual_sel | input | 1 | Manual source: 0 = A, 1 = B |
| sel_src | output | 1 | Selected source: 0 = A, 1 = B |
| sel_switch | output | 1 | One-cycle pulse when `sel_src` changes |
| act_status | output | 2 | Filtered activity: bit 0 = A, bit 1 = B |

## Verification
The bench builds the block with DEB_LINES = 4. At that value, a run one line short of the threshold, an interrupted run and the exact threshold line all take only a few strobes, so each boundary is checked on both sides. The short filter also lets the bench walk the automatic rule through every pair of activity states: the tie with A selected, B alone, A returning while B is held, and the drop of B with and without A present. At each step the bench samples status and selection on separate cycles to check the one-edge lag.

// File: rtl/input_autosel_pkg.sv
package input_autosel_pkg;
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  localparam int NUM_SRC = 2;
endpackage

// File: rtl/act_filter.sv
module act_filter #(
  parameter int DEB_LINES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic active
);
  localparam int CNT_W = (DEB_LINES > 2) ? $clog2(DEB_LINES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_LINES - 1);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      run_q  <= '0;
    end else if (tick) begin
      if (raw == active) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        active <= raw;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/src_policy.sv
module src_policy
  import input_autosel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic manual_sel,
  input  logic act_a,
  input  logic act_b,
  output src_e sel_q,
  output logic switch_q
);
  src_e next_src;

  always_comb begin
    if (!auto_en) begin
      next_src = manual_sel ? SRC_B : SRC_A;
    end else if (sel_q == SRC_B) begin
      next_src = act_b ? SRC_B : SRC_A;
    end else begin
      next_src = (act_b && !act_a) ? SRC_B : SRC_A;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SRC_A;
      switch_q <= 1'b0;
    end else begin
      sel_q    <= next_src;
      switch_q <= (next_src != sel_q);
    end
  end
endmodule

// File: rtl/input_autosel.sv
module input_autosel
  import input_autosel_pkg::*;
#(
  parameter int DEB_LINES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_tick,
  input  logic       sync_a,
  input  logic       sync_b,
  input  logic       auto_en,
  input  logic       manual_sel,
  output logic       sel_src,
  output logic       sel_switch,
  output logic [1:0] act_status
);
  logic [NUM_SRC-1:0] raw_vec;
  logic [NUM_SRC-1:0] act_vec;
  src_e               sel_e;

  assign raw_vec = {sync_b, sync_a};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_filt
    act_filter #(.DEB_LINES(DEB_LINES)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .tick   (line_tick),
      .raw    (raw_vec[g]),
      .active (act_vec[g])
    );
  end

  src_policy u_policy (
    .clk        (clk),
    .rst        (rst),
    .auto_en    (auto_en),
    .manual_sel (manual_sel),
    .act_a      (act_vec[0]),
    .act_b      (act_vec[1]),
    .sel_q      (sel_e),
    .switch_q   (sel_switch)
  );

  assign sel_src    = sel_e;
  assign act_status = act_vec;
endmodule

// File: rtl/input_autosel_chk.sv
module input_autosel_chk (
  input logic       clk,
  input logic       rst,
  input logic       line_tick,
  input logic       auto_en,
  input logic       manual_sel,
  input logic       sel_src,
  input logic       sel_switch,
  input logic [1:0] act_status
);
  p_manual_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> sel_src == $past(manual_sel));

  p_none_to_a_r3: assert property (@(posedge clk) disable iff (rst)
    (auto_en && act_status == 2'b00) |=> !sel_src);

  p_b_only_r4: assert property (@(posedge clk) disable iff (rst)
    (auto_en && act_status == 2'b10) |=> sel_src);

  p_tie_keeps_a_r5: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !sel_src && act_status == 2'b11) |=> !sel_src);

  p_hold_b_r6: assert property (@(posedge clk) disable iff (rst)
    (auto_en && sel_src && act_status[1]) |=> sel_src);

  p_status_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    !line_tick |=> $stable(act_status));

  p_pulse_marks_change_r10: assert property (@(posedge clk) disable iff (rst)
    sel_switch == (sel_src != $past(sel_src)));
endmodule

bind input_autosel input_autosel_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_tick  (line_tick),
  .auto_en    (auto_en),
  .manual_sel (manual_sel),
  .sel_src    (sel_src),
  .sel_switch (sel_switch),
  .act_status (act_status)
);

// File: tb/input_autosel_tb_top.sv
module input_autosel_tb_top;
  localparam int DEB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_tick = 1'b0;
  logic       sync_a = 1'b0;
  logic       sync_b = 1'b0;
  logic       auto_en = 1'b0;
  logic       manual_sel = 1'b0;
  logic       sel_src;
  logic       sel_switch;
  logic [1:0] act_status;

  int checks = 0;
  int errors = 0;
  logic sel_early;
  logic pulse_seen;

  always #10 clk = ~clk;

  input_autosel #(.DEB_LINES(DEB)) dut_i (
    .clk(clk), .rst(rst), .line_tick(line_tick), .sync_a(sync_a), .sync_b(sync_b),
    .auto_en(auto_en), .manual_sel(manual_sel), .sel_src(sel_src),
    .sel_switch(sel_switch), .act_status(act_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // One line: strobe, then status settles, then selection settles.
  task automatic line(input logic a, input logic b);
    @(negedge clk);
    sync_a = a; sync_b = b; line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    sel_early = sel_src;
    @(negedge clk);
    pulse_seen = sel_switch;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 sel", sel_src, 0);
    chk("R2 status", act_status, 0);
    chk("R2 pulse", sel_switch, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 sel after", sel_src, 0);
  endtask

  task automatic t_manual;
    auto_en = 1'b0;
    manual_sel = 1'b1;
    @(negedge clk);
    chk("R1 manual B", sel_src, 1);
    chk("R10 pulse", sel_switch, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", sel_switch, 0);
    manual_sel = 1'b0;
    @(negedge clk);
    chk("R1 manual A", sel_src, 0);
  endtask

  task automatic t_tie_after_reset;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    auto_en = 1'b1;
    for (int i = 0; i < DEB - 1; i++) line(1'b1, 1'b1);
    chk("R7 below threshold", act_status, 0);
    line(1'b1, 1'b1);
    chk("R7 threshold both", act_status, 3);
    chk("R5 tie keeps A", sel_src, 0);
    chk("R5 no pulse", pulse_seen, 0);
  endtask

  task automatic t_up;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    auto_en = 1'b1;
    for (int i = 0; i < DEB - 1; i++) line(1'b1, 1'b0);
    chk("R7 A short run", act_status, 0);
    line(1'b1, 1'b0);
    chk("R9 A bit0", act_status, 1);
    chk("R3 A only stays A", sel_src, 0);
    // interrupted run on B
    line(1'b1, 1'b1); line(1'b1, 1'b1); line(1'b1, 1'b0);
    for (int i = 0; i < DEB - 1; i++) line(1'b1, 1'b1);
    chk("R8 interrupted run restarts", act_status, 1);
    // sync held without strobes
    @(negedge clk); sync_b = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 no strobe no change", act_status, 1);
    line(1'b1, 1'b1);
    chk("R7 B threshold", act_status, 3);
    chk("R5 both keeps A", sel_src, 0);
  endtask

  task automatic t_b_only_and_sticky;
    for (int i = 0; i < DEB - 1; i++) line(1'b0, 1'b1);
    chk("R8 A not yet down", act_status, 3);
    line(1'b0, 1'b1);
    chk("R9 B bit1", act_status, 2);
    chk("R11 sel lags status", sel_early, 0);
    chk("R4 B only", sel_src, 1);
    chk("R10 pulse on switch", pulse_seen, 1);
    @(negedge clk);
    chk("R10 pulse ends", sel_switch, 0);
    for (int i = 0; i < DEB; i++) line(1'b1, 1'b1);
    chk("R6 A back status", act_status, 3);
    chk("R6 B held", sel_src, 1);
    for (int i = 0; i < DEB; i++) line(1'b1, 1'b0);
    chk("R8 B down", act_status, 1);
    chk("R6 release to A", sel_src, 0);
    chk("R10 pulse back", pulse_seen, 1);
  endtask

  task automatic t_none;
    for (int i = 0; i < DEB; i++) line(1'b0, 1'b1);
    chk("R4 B only again", sel_src, 1);
    for (int i = 0; i < DEB; i++) line(1'b0, 1'b0);
    chk("R8 both down", act_status, 0);
    chk("R3 none gives A", sel_src, 0);
  endtask

  initial begin
    t_reset();
    t_manual();
    t_tie_after_reset();
    t_up();
    t_b_only_and_sticky();
    t_none();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule